// File: doc/BRIEF.md
# Wide Register Write Collector

This block sits between a 32-bit host write port and a group of wide targets. The host can only write one dword per cycle. The targets come in three kinds: 128-bit control registers, 128-bit write-only descriptor pointers, and 64-bit memory words. A single staging buffer gathers the dwords of one target at a time. It remembers which dwords it holds and which target they belong to. When the value is complete, it issues one commit with the full-width data. Any address that falls outside the wide regions is treated as a plain 32-bit register, and its write is forwarded at once.

Descriptor pointers use a looser rule. A write to a pointer's top dword always commits that pointer. The lower 96 bits are committed as zero unless the buffer already holds the pointer's three lower dwords. A lower-dword write to a pointer is dropped while the buffer is collecting a different target. For ordinary wide targets, a write to a different target abandons the partial value and starts collecting the new target. The commit port is driven combinationally, so a commit appears in the same cycle as the write that causes it.

Top module: `wr_collector`

## Requirements
- R1: After reset the buffer is empty and no commit is issued while no write is presented; a lone dword written after reset does not commit.
- R2: A write to an address outside all wide regions commits in the same cycle with kind 0, index equal to the address, the data in bits 31:0 and zero above, and leaves the buffer untouched.
- R3: A 128-bit control register (kind 1) commits only on the write that supplies the last missing dword of its four. The dwords may arrive in any order. Dword k, selected by address bits 1:0, lands in bits 32k+31:32k.
- R4: A 64-bit memory word (kind 3) commits once both of its dwords are present. Address bit 0 selects the dword, and bits 127:64 of the commit are zero.
- R5: A write to an ordinary wide target other than the one held in a non-empty buffer discards the held dwords and starts collecting the new target.
- R6: A write to dword 3 of a descriptor pointer (kind 2) commits that pointer in the same cycle, whatever the buffer holds, with the written data in bits 127:96.
- R7: A pointer commit carries the buffered bits 95:0 only when the buffer holds dwords 0, 1 and 2 of that same pointer; otherwise bits 95:0 are zero.
- R8: A write to dwords 0 to 2 of a pointer while the buffer holds another target is discarded, and the buffer keeps its contents and owner.
- R9: Every wide or pointer commit empties the buffer, so a later commit of the same target needs all its dwords again.
- R10: The commit strobe is high only in a cycle in which a write is presented, and it is high for exactly that cycle.
- R11: The default dword address map is: control registers at 0 to 31 (index = address/4), pointers at 64 to 79 (index = (address-64)/4), memory words at 256 to 383 (index = (address-256)/2), and plain registers elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Host dword write present this cycle |
| wr_addr | input | ADDR_W | Dword address of the write |
| wr_data | input | 32 | Write data |
| cm_valid | output | 1 | Commit strobe, one cycle per commit |
| cm_kind | output | 2 | Target kind: 0 plain, 1 control, 2 pointer, 3 memory |
| cm_index | output | ADDR_W | Target index within its kind, or the address for plain |
| cm_data | output | 128 | Assembled value, zero-extended for narrower targets |

## Verification
The buffer's valid mask and owner are not visible at the ports. A fault in either shows up only at the next commit. A wrong mask commits a control register one write early or late, or fills a pointer's low bits where zeros were due. A wrong owner merges dwords from two targets into one commit. Because the commit port is combinational, each such error appears in the very cycle of the completing write. The bench compares the port against its model on every clock and mixes interleaved targets so that stale state reaches a commit within a few writes.

// File: rtl/wrc_pkg.sv
package wrc_pkg;
    typedef enum logic [1:0] {
        TK_PLAIN = 2'd0,
        TK_WIDE  = 2'd1,
        TK_PTR   = 2'd2,
        TK_MEM   = 2'd3
    } tgt_kind_e;
endpackage

// File: rtl/wrc_decode.sv
module wrc_decode
    import wrc_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int WIDE_LANES  = 4,
    parameter int MEM_LANES   = 2,
    parameter int WIDE_BASE   = 0,
    parameter int N_WIDE      = 8,
    parameter int PTR_BASE    = 64,
    parameter int N_PTR       = 4,
    parameter int MEM_BASE    = 256,
    parameter int N_MEM       = 64,
    parameter int LANE_W      = $clog2(WIDE_LANES)
) (
    input  logic [ADDR_W-1:0] addr,
    output tgt_kind_e         kind,
    output logic [ADDR_W-1:0] index,
    output logic [LANE_W-1:0] lane
);
    localparam int MEM_LW = $clog2(MEM_LANES);
    localparam logic [ADDR_W:0] W_LO = (ADDR_W+1)'(WIDE_BASE);
    localparam logic [ADDR_W:0] W_HI = (ADDR_W+1)'(WIDE_BASE + N_WIDE*WIDE_LANES);
    localparam logic [ADDR_W:0] P_LO = (ADDR_W+1)'(PTR_BASE);
    localparam logic [ADDR_W:0] P_HI = (ADDR_W+1)'(PTR_BASE + N_PTR*WIDE_LANES);
    localparam logic [ADDR_W:0] M_LO = (ADDR_W+1)'(MEM_BASE);
    localparam logic [ADDR_W:0] M_HI = (ADDR_W+1)'(MEM_BASE + N_MEM*MEM_LANES);

    logic [ADDR_W:0]   a_ext;
    logic              in_wide, in_ptr, in_mem;
    logic [ADDR_W-1:0] off_w, off_p, off_m;

    always_comb begin
        a_ext   = {1'b0, addr};
        in_wide = (a_ext >= W_LO) && (a_ext < W_HI);
        in_ptr  = (a_ext >= P_LO) && (a_ext < P_HI);
        in_mem  = (a_ext >= M_LO) && (a_ext < M_HI);
        off_w   = addr - W_LO[ADDR_W-1:0];
        off_p   = addr - P_LO[ADDR_W-1:0];
        off_m   = addr - M_LO[ADDR_W-1:0];

        kind  = TK_PLAIN;
        index = addr;
        lane  = '0;
        if (in_wide) begin
            kind  = TK_WIDE;
            index = off_w >> LANE_W;
            lane  = off_w[LANE_W-1:0];
        end else if (in_ptr) begin
            kind  = TK_PTR;
            index = off_p >> LANE_W;
            lane  = off_p[LANE_W-1:0];
        end else if (in_mem) begin
            kind  = TK_MEM;
            index = off_m >> MEM_LW;
            lane  = LANE_W'(off_m[MEM_LW-1:0]);
        end
    end
endmodule

// File: rtl/wrc_lane_merge.sv
module wrc_lane_merge #(
    parameter int DW_W   = 32,
    parameter int LANES  = 4,
    parameter int LANE_W = $clog2(LANES)
) (
    input  logic [LANES*DW_W-1:0] base_data,
    input  logic [LANES-1:0]      base_mask,
    input  logic [LANE_W-1:0]     lane,
    input  logic [DW_W-1:0]       wdata,
    output logic [LANES*DW_W-1:0] out_data,
    output logic [LANES-1:0]      out_mask
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic hit;
        assign hit = (lane == LANE_W'(g));
        assign out_data[g*DW_W +: DW_W] = hit ? wdata : base_data[g*DW_W +: DW_W];
        assign out_mask[g] = hit | base_mask[g];
    end
endmodule

// File: rtl/wrc_stage.sv
module wrc_stage
    import wrc_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int DW_W       = 32,
    parameter int WIDE_LANES = 4,
    parameter int MEM_LANES  = 2,
    parameter int LANE_W     = $clog2(WIDE_LANES)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_valid,
    input  tgt_kind_e                  in_kind,
    input  logic [ADDR_W-1:0]          in_index,
    input  logic [LANE_W-1:0]          in_lane,
    input  logic [DW_W-1:0]            in_data,
    output logic                       out_valid,
    output tgt_kind_e                  out_kind,
    output logic [ADDR_W-1:0]          out_index,
    output logic [DW_W*WIDE_LANES-1:0] out_data,
    output logic [WIDE_LANES-1:0]      buf_mask,
    output tgt_kind_e                  buf_kind,
    output logic [ADDR_W-1:0]          buf_idx
);
    localparam int WIDE_W = DW_W * WIDE_LANES;
    localparam int MEM_W  = DW_W * MEM_LANES;
    localparam int LOW_W  = WIDE_W - DW_W;
    localparam logic [LANE_W-1:0] TOP_LANE = LANE_W'(WIDE_LANES - 1);

    typedef struct packed {
        logic [WIDE_LANES-1:0] mask;
        tgt_kind_e             kind;
        logic [ADDR_W-1:0]     idx;
        logic [WIDE_W-1:0]     data;
    } stage_t;

    stage_t st_d, st_q;

    logic                  same_tgt;
    logic                  busy;
    logic [WIDE_W-1:0]     base_data, m_data;
    logic [WIDE_LANES-1:0] base_mask, m_mask;
    logic                  full;

    always_comb begin
        busy      = (st_q.mask != '0);
        same_tgt  = busy && (st_q.kind == in_kind) && (st_q.idx == in_index);
        base_data = same_tgt ? st_q.data : '0;
        base_mask = same_tgt ? st_q.mask : '0;
    end

    wrc_lane_merge #(
        .DW_W   (DW_W),
        .LANES  (WIDE_LANES),
        .LANE_W (LANE_W)
    ) u_merge (
        .base_data (base_data),
        .base_mask (base_mask),
        .lane      (in_lane),
        .wdata     (in_data),
        .out_data  (m_data),
        .out_mask  (m_mask)
    );

    always_comb begin
        st_d      = st_q;
        out_valid = 1'b0;
        out_kind  = TK_PLAIN;
        out_index = '0;
        out_data  = '0;
        full      = (in_kind == TK_WIDE) ? (&m_mask) : (&m_mask[MEM_LANES-1:0]);

        if (wr_valid) begin
            unique case (in_kind)
                TK_PLAIN: begin
                    out_valid           = 1'b1;
                    out_kind            = TK_PLAIN;
                    out_index           = in_index;
                    out_data[DW_W-1:0]  = in_data;
                end
                TK_WIDE, TK_MEM: begin
                    if (full) begin
                        out_valid = 1'b1;
                        out_kind  = in_kind;
                        out_index = in_index;
                        if (in_kind == TK_MEM) out_data[MEM_W-1:0] = m_data[MEM_W-1:0];
                        else                   out_data = m_data;
                        st_d.mask = '0;
                        st_d.kind = TK_PLAIN;
                        st_d.idx  = '0;
                        st_d.data = '0;
                    end else begin
                        st_d.mask = m_mask;
                        st_d.kind = in_kind;
                        st_d.idx  = in_index;
                        st_d.data = m_data;
                    end
                end
                TK_PTR: begin
                    if (in_lane == TOP_LANE) begin
                        out_valid = 1'b1;
                        out_kind  = TK_PTR;
                        out_index = in_index;
                        out_data[WIDE_W-1:LOW_W] = in_data;
                        if (same_tgt && (&st_q.mask[WIDE_LANES-2:0]))
                            out_data[LOW_W-1:0] = m_data[LOW_W-1:0];
                        st_d.mask = '0;
                        st_d.kind = TK_PLAIN;
                        st_d.idx  = '0;
                        st_d.data = '0;
                    end else if (!(busy && !same_tgt)) begin
                        st_d.mask = m_mask;
                        st_d.kind = TK_PTR;
                        st_d.idx  = in_index;
                        st_d.data = m_data;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mask <= '0;
            st_q.kind <= TK_PLAIN;
            st_q.idx  <= '0;
            st_q.data <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign buf_mask = st_q.mask;
    assign buf_kind = st_q.kind;
    assign buf_idx  = st_q.idx;
endmodule

// File: rtl/wr_collector.sv
module wr_collector
    import wrc_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int DW_W       = 32,
    parameter int WIDE_LANES = 4,
    parameter int MEM_LANES  = 2,
    parameter int WIDE_BASE  = 0,
    parameter int N_WIDE     = 8,
    parameter int PTR_BASE   = 64,
    parameter int N_PTR      = 4,
    parameter int MEM_BASE   = 256,
    parameter int N_MEM      = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_valid,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DW_W-1:0]            wr_data,
    output logic                       cm_valid,
    output logic [1:0]                 cm_kind,
    output logic [ADDR_W-1:0]          cm_index,
    output logic [DW_W*WIDE_LANES-1:0] cm_data
);
    localparam int LANE_W = $clog2(WIDE_LANES);

    tgt_kind_e             dec_kind;
    logic [ADDR_W-1:0]     dec_index;
    logic [LANE_W-1:0]     dec_lane;
    tgt_kind_e             stg_kind;
    logic [WIDE_LANES-1:0] buf_mask;
    tgt_kind_e             buf_kind;
    logic [ADDR_W-1:0]     buf_idx;

    wrc_decode #(
        .ADDR_W     (ADDR_W),
        .WIDE_LANES (WIDE_LANES),
        .MEM_LANES  (MEM_LANES),
        .WIDE_BASE  (WIDE_BASE),
        .N_WIDE     (N_WIDE),
        .PTR_BASE   (PTR_BASE),
        .N_PTR      (N_PTR),
        .MEM_BASE   (MEM_BASE),
        .N_MEM      (N_MEM),
        .LANE_W     (LANE_W)
    ) u_dec (
        .addr  (wr_addr),
        .kind  (dec_kind),
        .index (dec_index),
        .lane  (dec_lane)
    );

    wrc_stage #(
        .ADDR_W     (ADDR_W),
        .DW_W       (DW_W),
        .WIDE_LANES (WIDE_LANES),
        .MEM_LANES  (MEM_LANES),
        .LANE_W     (LANE_W)
    ) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .in_kind   (dec_kind),
        .in_index  (dec_index),
        .in_lane   (dec_lane),
        .in_data   (wr_data),
        .out_valid (cm_valid),
        .out_kind  (stg_kind),
        .out_index (cm_index),
        .out_data  (cm_data),
        .buf_mask  (buf_mask),
        .buf_kind  (buf_kind),
        .buf_idx   (buf_idx)
    );

    assign cm_kind = stg_kind;
endmodule

// File: rtl/wrc_check.sv
module wrc_check #(
    parameter int ADDR_W     = 10,
    parameter int DW_W       = 32,
    parameter int WIDE_LANES = 4,
    parameter int MEM_LANES  = 2,
    parameter int LANE_W     = $clog2(WIDE_LANES)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_valid,
    input logic [ADDR_W-1:0]          wr_addr,
    input logic [DW_W-1:0]            wr_data,
    input logic                       cm_valid,
    input logic [1:0]                 cm_kind,
    input logic [ADDR_W-1:0]          cm_index,
    input logic [DW_W*WIDE_LANES-1:0] cm_data,
    input logic [1:0]                 dec_kind,
    input logic [ADDR_W-1:0]          dec_index,
    input logic [LANE_W-1:0]          dec_lane,
    input logic [WIDE_LANES-1:0]      buf_mask,
    input logic [1:0]                 buf_kind,
    input logic [ADDR_W-1:0]          buf_idx
);
    localparam int WIDE_W = DW_W * WIDE_LANES;
    localparam int MEM_W  = DW_W * MEM_LANES;
    localparam int LOW_W  = WIDE_W - DW_W;
    localparam logic [LANE_W-1:0] TOP = LANE_W'(WIDE_LANES - 1);
    localparam logic [1:0] K_PLAIN = 2'd0, K_WIDE = 2'd1, K_PTR = 2'd2, K_MEM = 2'd3;

    // R10
    a_r10_strobe_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        cm_valid |-> wr_valid);

    // R2
    a_r2_plain_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && dec_kind == K_PLAIN) |->
        (cm_valid && cm_kind == K_PLAIN && cm_index == wr_addr &&
         cm_data[DW_W-1:0] == wr_data && cm_data[WIDE_W-1:DW_W] == '0));

    // R3
    a_r3_wide_last_dword: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_valid && cm_kind == K_WIDE) |->
        (buf_kind == K_WIDE && buf_idx == cm_index && $countones(buf_mask) == WIDE_LANES - 1));

    // R4
    a_r4_mem_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_valid && cm_kind == K_MEM) |-> (cm_data[WIDE_W-1:MEM_W] == '0));

    // R6
    a_r6_ptr_top_commits: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && dec_kind == K_PTR && dec_lane == TOP) |->
        (cm_valid && cm_kind == K_PTR && cm_index == dec_index &&
         cm_data[WIDE_W-1:LOW_W] == wr_data));

    // R7
    a_r7_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_valid && cm_kind == K_PTR &&
         !((&buf_mask[WIDE_LANES-2:0]) && buf_kind == K_PTR && buf_idx == cm_index)) |->
        (cm_data[LOW_W-1:0] == '0));

    // R8
    a_r8_discard_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && dec_kind == K_PTR && dec_lane != TOP && buf_mask != '0 &&
         !(buf_kind == K_PTR && buf_idx == dec_index)) |=>
        ($stable(buf_mask) && $stable(buf_kind) && $stable(buf_idx)));

    // R9
    a_r9_commit_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_valid && cm_kind != K_PLAIN) |=> (buf_mask == '0));
endmodule

bind wr_collector wrc_check #(
    .ADDR_W     (ADDR_W),
    .DW_W       (DW_W),
    .WIDE_LANES (WIDE_LANES),
    .MEM_LANES  (MEM_LANES),
    .LANE_W     (LANE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .cm_valid  (cm_valid),
    .cm_kind   (cm_kind),
    .cm_index  (cm_index),
    .cm_data   (cm_data),
    .dec_kind  (dec_kind),
    .dec_index (dec_index),
    .dec_lane  (dec_lane),
    .buf_mask  (buf_mask),
    .buf_kind  (buf_kind),
    .buf_idx   (buf_idx)
);

// File: tb/wr_collector_test.sv
module wr_collector_test;
    localparam int CLK_P  = 10;
    localparam int ADDR_W = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_valid = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic              cm_valid;
    logic [1:0]        cm_kind;
    logic [ADDR_W-1:0] cm_index;
    logic [127:0]      cm_data;

    int checks = 0;
    int errors = 0;

    // behavioural model state
    int          m_mask = 0;
    int          m_kind = 0;
    int          m_idx  = 0;
    logic [31:0] m_dw [4];

    always #(CLK_P/2) clk = ~clk;

    wr_collector uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .cm_valid (cm_valid),
        .cm_kind  (cm_kind),
        .cm_index (cm_index),
        .cm_data  (cm_data)
    );

    // address map of R11: kind 0 plain, 1 control, 2 pointer, 3 memory
    task automatic decode(input int a, output int k, output int ix, output int ln);
        if (a < 32) begin
            k = 1; ix = a / 4; ln = a % 4;
        end else if (a >= 64 && a < 80) begin
            k = 2; ix = (a - 64) / 4; ln = (a - 64) % 4;
        end else if (a >= 256 && a < 384) begin
            k = 3; ix = (a - 256) / 2; ln = (a - 256) % 2;
        end else begin
            k = 0; ix = a; ln = 0;
        end
    endtask

    task automatic model_clear();
        m_mask = 0; m_kind = 0; m_idx = 0;
        for (int i = 0; i < 4; i++) m_dw[i] = '0;
    endtask

    task automatic step(input bit v, input int a, input logic [31:0] d, input string req);
        int k, ix, ln;
        bit same, ev;
        int ek, ei;
        logic [127:0] ed;
        string tag;
        @(negedge clk);
        wr_valid = v;
        wr_addr  = ADDR_W'(a);
        wr_data  = d;
        #1;
        ev = 0; ek = 0; ei = 0; ed = '0; tag = req;
        if (v) begin
            decode(a, k, ix, ln);
            same = (m_mask != 0) && (m_kind == k) && (m_idx == ix);
            if (k == 0) begin
                ev = 1; ek = 0; ei = ix; ed[31:0] = d;
            end else if (k == 1 || k == 3) begin
                if (!same) model_clear();
                m_kind = k; m_idx = ix;
                m_mask = m_mask | (1 << ln);
                m_dw[ln] = d;
                if ((k == 1 && m_mask == 15) || (k == 3 && m_mask == 3)) begin
                    ev = 1; ek = k; ei = ix;
                    ed[31:0]  = m_dw[0];
                    ed[63:32] = m_dw[1];
                    if (k == 1) begin
                        ed[95:64]  = m_dw[2];
                        ed[127:96] = m_dw[3];
                    end
                    model_clear();
                end
            end else begin
                if (ln == 3) begin
                    ev = 1; ek = 2; ei = ix;
                    ed[127:96] = d;
                    if (same && (m_mask & 7) == 7) begin
                        ed[31:0] = m_dw[0]; ed[63:32] = m_dw[1]; ed[95:64] = m_dw[2];
                    end
                    model_clear();
                end else if (m_mask == 0 || same) begin
                    m_kind = 2; m_idx = ix;
                    m_mask = m_mask | (1 << ln);
                    m_dw[ln] = d;
                end
            end
        end
        checks++;
        if (cm_valid !== ev ||
            (ev && (int'(cm_kind) != ek || int'(cm_index) != ei || cm_data !== ed))) begin
            errors++;
            $display("FAIL %s: got v=%0b k=%0d i=%0d d=%h exp v=%0b k=%0d i=%0d d=%h",
                     tag, cm_valid, cm_kind, cm_index, cm_data, ev, ek, ei, ed);
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: idle after reset, then lone dword does not commit
        step(0, 0, 0, "R1");
        step(1, 7, 32'hA0000003, "R1");
        step(0, 0, 0, "R1");
        // R2: plain registers, buffer (control 1) left alone
        step(1, 512, 32'hDEADBEEF, "R2");
        step(1, 1023, 32'h12345678, "R2");
        step(1, 40, 32'h0BADF00D, "R2");
        // R3: control 2 in order 2,0,3,1 (R11 decode)
        step(1, 10, 32'h22222222, "R3");
        step(1, 8,  32'h00000000, "R3");
        step(1, 11, 32'h33333333, "R3");
        step(1, 9,  32'h11111111, "R3");
        // R4: memory word 5, dword 1 then 0
        step(1, 267, 32'hCAFE0001, "R4");
        step(1, 266, 32'hCAFE0000, "R4");
        // R5: control 1 partial, then control 3 full, then control 1 remainder
        step(1, 4, 32'h40000000, "R5");
        step(1, 5, 32'h50000000, "R5");
        step(1, 12, 32'hC0, "R5");
        step(1, 13, 32'hC1, "R5");
        step(1, 14, 32'hC2, "R5");
        step(1, 15, 32'hC3, "R5");
        step(1, 6, 32'h60000000, "R5");
        step(1, 7, 32'h70000000, "R5");
        step(1, 4, 32'h4, "R5");
        step(1, 5, 32'h5, "R5");
        // R6/R7: pointer 1 full, pointer 2 top alone, pointer 0 partial
        step(1, 68, 32'hF0, "R7");
        step(1, 69, 32'hF1, "R7");
        step(1, 70, 32'hF2, "R7");
        step(1, 71, 32'hF3, "R6");
        step(1, 75, 32'hE3, "R6");
        step(1, 64, 32'hD0, "R7");
        step(1, 66, 32'hD2, "R7");
        step(1, 67, 32'hD3, "R7");
        // R8: control 0 partial, pointer 1 low write discarded
        step(1, 0, 32'hAA000000, "R8");
        step(1, 69, 32'hBB, "R8");
        step(1, 1, 32'hAA000001, "R8");
        step(1, 2, 32'hAA000002, "R8");
        step(1, 3, 32'hAA000003, "R8");
        // R9: top pointer write while control 0 partial, then control 0 needs refill
        step(1, 0, 32'h1, "R9");
        step(1, 1, 32'h2, "R9");
        step(1, 79, 32'h99, "R9");
        step(1, 2, 32'h3, "R9");
        step(1, 3, 32'h4, "R9");
        step(1, 1, 32'h5, "R9");
        // R10: strobe only with a write
        step(0, 3, 32'h0, "R10");
        // mixed traffic
        for (int n = 0; n < 600; n++) begin
            int sel, a;
            sel = $urandom_range(0, 5);
            case (sel)
                0: a = $urandom_range(0, 7);
                1: a = 64 + $urandom_range(0, 7);
                2: a = 256 + $urandom_range(0, 3);
                3: a = 400 + $urandom_range(0, 20);
                default: a = (n % 2) ? 64 + $urandom_range(0, 7) : $urandom_range(0, 7);
            endcase
            step(sel != 5 || (n % 3 != 0), a, $urandom, "R11");
        end
        step(0, 0, 0, "R10");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule